// File: doc/BRIEF.md
# Static Memory Read Strobe Timer

This block runs one read access on an external asynchronous static memory, counting every interval in master-clock cycles. When the host raises a request while the block is idle, the block drives the request address onto the 24-bit external address pins. It then shapes two active-low strobes, a read enable and a chip select. Each strobe has its own programmable setup, pulse and hold counts. The byte on the 8-bit data pins is captured as the read enable is released, and a one-cycle ready pulse tells the host that the access has finished.

Both strobes start from the same point, the cycle in which the address becomes valid, and they share one end of cycle. When the two configured sums (setup + pulse + hold) disagree, the longer sum sets the cycle length, the shorter strobe's hold is stretched to fill the gap, and a configuration error flag is raised for that access. The timing inputs are sampled when a request is accepted and have no effect after that.

The controller has three states. In IDLE it waits; the transition IDLE->RUN ("accept") happens on a request. In RUN it counts cycles; the transition RUN->DONE ("last cycle") happens when the count reaches the cycle length minus one, and otherwise RUN stays in RUN ("count"). DONE asserts ready for one cycle, and the transition DONE->IDLE ("release") is unconditional.

Top module: `smc_read_timer`

## Requirements
- R1: After reset, mem_re_n and mem_cs_n are 1, and ready, cfg_err, rd_data and mem_addr are all 0.
- R2: mem_addr takes the value of req_addr on the clock edge that accepts a request. It keeps that value for the whole access and afterwards, until the next accepted request.
- R3: Number the cycles after the accepting edge k = 0, 1, 2, ... . mem_re_n is 0 exactly in the cycles with re_setup <= k < re_setup + P, where P is re_pulse, or 1 when re_pulse is 0. In every other cycle, including all idle cycles, mem_re_n is 1.
- R4: mem_cs_n follows the same rule as R3, using cs_setup and cs_pulse, with a zero pulse count taken as 1.
- R5: The cycle length T is the larger of the two effective sums (setup + effective pulse + hold). ready is 1 in cycle k = T only, and it is a single-cycle pulse.
- R6: cfg_err is 1 from cycle 0 of an access until the next accepted request exactly when the two effective sums differ. Otherwise it is 0.
- R7: rd_data takes the value of mem_data on the clock edge at which mem_re_n returns to 1 (the edge that ends cycle re_setup + P - 1). It does not change at any other time.
- R8: A request is accepted only in IDLE. A request held during RUN or DONE is ignored: the strobes, the address and the cycle length do not change, and no further access follows it.
- R9: Timing inputs that change after the accepting edge have no effect on the access already in progress.
- R10: Setup and hold counts of zero are legal. A setup of 0 drives the strobe low in cycle 0. A pulse of 0 gives a one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, accepted only when idle |
| req_addr | input | ADDR_W | Address to read |
| re_setup | input | CNT_W | Read-enable setup cycles |
| re_pulse | input | CNT_W | Read-enable pulse cycles (0 acts as 1) |
| re_hold | input | CNT_W | Read-enable hold cycles |
| cs_setup | input | CNT_W | Chip-select setup cycles |
| cs_pulse | input | CNT_W | Chip-select pulse cycles (0 acts as 1) |
| cs_hold | input | CNT_W | Chip-select hold cycles |
| ready | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | The two strobe sums differed for this access |
| rd_data | output | DATA_W | Captured read byte |
| mem_addr | output | ADDR_W | External address bus |
| mem_data | input | DATA_W | External data bus |
| mem_re_n | output | 1 | Active-low read enable |
| mem_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with ADDR_W=24 and DATA_W=8 as specified, but narrows CNT_W to 4. With that width, random draws often hit zero counts, all-ones counts (a 45-cycle access) and sums that differ widely, so stretched holds, one-cycle pulses and setup-of-zero strobes show up again and again within a short run. The memory model returns a fixed filler byte whenever mem_re_n is high, so a capture one edge late shows up as a wrong byte.

// File: rtl/smc_rd_pkg.sv
package smc_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rd_state_t;

    localparam int STB_RE = 0;
    localparam int STB_CS = 1;
    localparam int NSTB   = 2;
endpackage

// File: rtl/smc_rd_cycle_calc.sv
module smc_rd_cycle_calc #(
    parameter int CNT_W = 8,
    parameter int NSTB  = 2,
    localparam int SUM_W = CNT_W + 2
) (
    input  logic [NSTB-1:0][CNT_W-1:0] setup,
    input  logic [NSTB-1:0][CNT_W-1:0] pulse,
    input  logic [NSTB-1:0][CNT_W-1:0] hold,
    output logic [NSTB-1:0][CNT_W-1:0] pulse_eff,
    output logic [SUM_W-1:0]           total,
    output logic                       mismatch
);
    logic [NSTB-1:0][SUM_W-1:0] sum;

    for (genvar i = 0; i < NSTB; i++) begin : g_sum
        always_comb begin
            pulse_eff[i] = (pulse[i] == '0) ? CNT_W'(1) : pulse[i];
            sum[i] = {2'b00, setup[i]} + {2'b00, pulse_eff[i]} + {2'b00, hold[i]};
        end
    end

    always_comb begin
        total    = sum[0];
        mismatch = 1'b0;
        for (int i = 1; i < NSTB; i++) begin
            if (sum[i] > total) total = sum[i];
            if (sum[i] != sum[0]) mismatch = 1'b1;
        end
    end
endmodule

// File: rtl/smc_rd_strobe_gen.sv
module smc_rd_strobe_gen #(
    parameter int CNT_W = 8,
    localparam int SUM_W = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_nxt,
    input  logic [SUM_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] setup,
    input  logic [CNT_W-1:0] pulse_eff,
    output logic             strobe_n
);
    logic [SUM_W-1:0] lo_edge;
    logic [SUM_W-1:0] hi_edge;
    logic             low_nxt;

    always_comb begin
        lo_edge = {2'b00, setup};
        hi_edge = lo_edge + {2'b00, pulse_eff};
        low_nxt = run_nxt && (cnt_nxt >= lo_edge) && (cnt_nxt < hi_edge);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_n <= 1'b1;
        else        strobe_n <= !low_nxt;
    end
endmodule

// File: rtl/smc_read_timer.sv
module smc_read_timer
    import smc_rd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  re_setup,
    input  logic [CNT_W-1:0]  re_pulse,
    input  logic [CNT_W-1:0]  re_hold,
    input  logic [CNT_W-1:0]  cs_setup,
    input  logic [CNT_W-1:0]  cs_pulse,
    input  logic [CNT_W-1:0]  cs_hold,
    output logic              ready,
    output logic              cfg_err,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic              mem_re_n,
    output logic              mem_cs_n
);
    localparam int SUM_W = CNT_W + 2;

    rd_state_t state, state_nxt;
    logic [SUM_W-1:0] cnt, cnt_nxt;
    logic             run_nxt;
    logic             accept;

    logic [NSTB-1:0][CNT_W-1:0] set_in, pul_in, hld_in;
    logic [NSTB-1:0][CNT_W-1:0] set_q, pul_q, hld_q;
    logic [NSTB-1:0][CNT_W-1:0] set_use, pul_use, hld_use, pe_use;
    logic [SUM_W-1:0]           total_use;
    logic                       mis_use;
    logic [SUM_W-1:0]           re_last;
    logic [NSTB-1:0]            stb_n;

    assign accept = req && (state == ST_IDLE);

    always_comb begin
        set_in[STB_RE] = re_setup;
        pul_in[STB_RE] = re_pulse;
        hld_in[STB_RE] = re_hold;
        set_in[STB_CS] = cs_setup;
        pul_in[STB_CS] = cs_pulse;
        hld_in[STB_CS] = cs_hold;
    end

    // timing captured at acceptance; the accepting cycle uses the live inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= '0;
            pul_q <= '0;
            hld_q <= '0;
        end else if (accept) begin
            set_q <= set_in;
            pul_q <= pul_in;
            hld_q <= hld_in;
        end
    end

    always_comb begin
        set_use = accept ? set_in : set_q;
        pul_use = accept ? pul_in : pul_q;
        hld_use = accept ? hld_in : hld_q;
    end

    smc_rd_cycle_calc #(.CNT_W(CNT_W), .NSTB(NSTB)) u_calc (
        .setup     (set_use),
        .pulse     (pul_use),
        .hold      (hld_use),
        .pulse_eff (pe_use),
        .total     (total_use),
        .mismatch  (mis_use)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    state_nxt = ST_RUN;
                    cnt_nxt   = '0;
                end
            end
            ST_RUN: begin
                if (cnt == total_use - SUM_W'(1)) state_nxt = ST_DONE;
                else                              cnt_nxt   = cnt + SUM_W'(1);
            end
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
        run_nxt = (state_nxt == ST_RUN);
    end

    for (genvar i = 0; i < NSTB; i++) begin : g_stb
        smc_rd_strobe_gen #(.CNT_W(CNT_W)) u_stb (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_nxt   (run_nxt),
            .cnt_nxt   (cnt_nxt),
            .setup     (set_use[i]),
            .pulse_eff (pe_use[i]),
            .strobe_n  (stb_n[i])
        );
    end

    assign mem_re_n = stb_n[STB_RE];
    assign mem_cs_n = stb_n[STB_CS];
    assign ready    = (state == ST_DONE);
    assign re_last  = {2'b00, set_use[STB_RE]} + {2'b00, pe_use[STB_RE]} - SUM_W'(1);

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            cfg_err  <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                cfg_err  <= mis_use;
            end
            if ((state == ST_RUN) && (cnt == re_last)) rd_data <= mem_data;
        end
    end

    assert_idle_re_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> mem_re_n);
    assert_idle_cs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> mem_cs_n);
    assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(mem_addr));
    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(cfg_err));
    assert_rd_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(mem_re_n) |-> $stable(rd_data));
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_RUN) |-> ($stable(set_q) && $stable(pul_q) && $stable(hld_q)));
    assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(mem_addr));
endmodule

// File: tb/test_smc_read_timer.sv
module test_smc_read_timer;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0] re_setup = '0, re_pulse = '0, re_hold = '0;
    logic [CNT_W-1:0] cs_setup = '0, cs_pulse = '0, cs_hold = '0;
    logic ready, cfg_err, mem_re_n, mem_cs_n;
    logic [DATA_W-1:0] rd_data, mem_data;
    logic [ADDR_W-1:0] mem_addr;

    int n_checks = 0;
    int n_fails = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    assign mem_data = mem_re_n ? 8'hA5 : mem_byte(mem_addr);

    smc_read_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_smc_read_timer (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .re_setup(re_setup), .re_pulse(re_pulse), .re_hold(re_hold),
        .cs_setup(cs_setup), .cs_pulse(cs_pulse), .cs_hold(cs_hold),
        .ready(ready), .cfg_err(cfg_err), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_re_n(mem_re_n), .mem_cs_n(mem_cs_n)
    );

    function automatic int peff(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic bit strobe_low(input int k, input int s, input int p);
        return (k >= s) && (k < s + peff(p));
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    task automatic run_access(input logic [23:0] a, input int rs, input int rp, input int rh,
                              input int cs, input int cp, input int ch,
                              input bit scramble, input bit poke);
        int s_re, s_cs, t;
        bit err;
        logic [7:0] exp_d;
        s_re = rs + peff(rp) + rh;
        s_cs = cs + peff(cp) + ch;
        t = (s_re > s_cs) ? s_re : s_cs;
        err = (s_re != s_cs);
        exp_d = mem_byte(a);
        @(negedge clk);
        req_addr = a; req = 1'b1;
        re_setup = rs[CNT_W-1:0]; re_pulse = rp[CNT_W-1:0]; re_hold = rh[CNT_W-1:0];
        cs_setup = cs[CNT_W-1:0]; cs_pulse = cp[CNT_W-1:0]; cs_hold = ch[CNT_W-1:0];
        for (int k = 0; k < t; k++) begin
            @(negedge clk);
            req = poke && (k < t - 1);
            if (scramble) begin
                re_setup = CNT_W'($urandom); re_pulse = CNT_W'($urandom); re_hold = CNT_W'($urandom);
                cs_setup = CNT_W'($urandom); cs_pulse = CNT_W'($urandom); cs_hold = CNT_W'($urandom);
                req_addr = ADDR_W'($urandom);
            end
            chk(mem_addr == a, "R2 addr", mem_addr, a);
            chk(mem_re_n == !strobe_low(k, rs, rp), "R3 re_n", mem_re_n, !strobe_low(k, rs, rp));
            chk(mem_cs_n == !strobe_low(k, cs, cp), "R4 cs_n", mem_cs_n, !strobe_low(k, cs, cp));
            chk(ready == 1'b0, "R5 ready early", ready, 0);
            if (k == 0) chk(cfg_err == err, "R6 cfg_err", cfg_err, err);
        end
        @(negedge clk);
        req = 1'b0;
        chk(ready == 1'b1, "R5 ready at T", ready, 1);
        chk(mem_re_n && mem_cs_n, "R3 strobes high at T", {mem_re_n, mem_cs_n}, 2'b11);
        chk(rd_data == exp_d, "R7 rd_data", rd_data, exp_d);
        chk(cfg_err == err, "R6 cfg_err held", cfg_err, err);
        @(negedge clk);
        chk(ready == 1'b0, "R5 ready single", ready, 0);
        chk(mem_re_n && mem_cs_n, "R8 no restart", {mem_re_n, mem_cs_n}, 2'b11);
        chk(mem_addr == a, "R2 addr after", mem_addr, a);
        chk(rd_data == exp_d, "R7 rd_data held", rd_data, exp_d);
    endtask

    initial begin
        int cyc = 0;
        while (!done_flag) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                chk(1'b0, "watchdog", cyc, WATCHDOG);
                summary();
            end
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        chk(mem_re_n == 1'b1 && mem_cs_n == 1'b1, "R1 strobes in reset", {mem_re_n, mem_cs_n}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0, "R1 ready", ready, 0);
        chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
        chk(rd_data == '0, "R1 rd_data", rd_data, 0);
        chk(mem_addr == '0, "R1 mem_addr", mem_addr, 0);
        chk(mem_re_n && mem_cs_n, "R1 strobes", {mem_re_n, mem_cs_n}, 2'b11);

        // directed corners
        run_access(24'h123456, 2, 3, 1, 1, 4, 1, 0, 0);   // equal sums
        run_access(24'hABCDEF, 0, 0, 0, 0, 0, 0, 0, 0);   // R10 all zero, T=1
        run_access(24'h00F00F, 1, 2, 0, 0, 6, 2, 0, 0);   // R6 mismatch, stretched hold
        run_access(24'hFFFFFF, 15, 15, 15, 15, 15, 15, 0, 0); // max counts
        run_access(24'h5A5A01, 3, 0, 0, 0, 0, 9, 0, 0);   // R10 zero pulse with setup
        run_access(24'h010203, 2, 2, 2, 0, 3, 1, 1, 1);   // R8 req held, R9 scramble

        for (int n = 0; n < 40; n++) begin
            run_access(ADDR_W'($urandom), $urandom_range(0, 15), $urandom_range(0, 15),
                       $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                       $urandom_range(0, 15), 1'($urandom), 1'($urandom));
        end
        done_flag = 1;
        summary();
    end
endmodule